// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This block is a 512-bit integer multiply-accumulate datapath for inference-style kernels. Two source vectors of packed small integers are multiplied element by element. Each 32-bit accumulator lane then receives a short dot product. In byte mode a lane sums four adjacent byte products. In word mode it sums two adjacent 16-bit products. That sum is added to the lane's previous accumulator value, and the result replaces the accumulator operand.

A per-lane write enable lets masked-off lanes pass their accumulator value through untouched. A saturate control picks between wrap-around and clamped addition on the final accumulate.

Operations enter through a valid/ready handshake and flow down a three-stage pipeline: multiply, reduce, accumulate. The block accepts one full-width operation per cycle. When the consumer deasserts its ready, the whole pipeline freezes.

Top module: `byte_dot_mac`

## Requirements
- R1: With `mode_word`=0, result lane k (bits 32k+31:32k) equals `acc_in` lane k plus the sum over i=0..3 of `src_a` byte (4k+i) × `src_b` byte (4k+i). Byte j sits at bits 8j+7:8j. The `src_a` bytes are unsigned and the `src_b` bytes are signed.
- R2: With `mode_word`=1, result lane k equals `acc_in` lane k plus `src_a` half (2k) × `src_b` half (2k) plus `src_a` half (2k+1) × `src_b` half (2k+1). Half j sits at bits 16j+15:16j, and both operands are signed.
- R3: The product sum of each lane is formed at full precision before the accumulate. In byte mode it always lies in [-130560, 129540], and the worst-case byte inputs (all 0xFF against all 0x80) give exactly -130560 with no intermediate wrap.
- R4: With `sat_en`=0, the accumulate wraps modulo 2^32.
- R5: With `sat_en`=1, the accumulate clamps to the signed 32-bit range: 0x7FFFFFFF on positive overflow and 0x80000000 on negative overflow.
- R6: When `wr_mask` bit k is 0, result lane k equals `acc_in` lane k, whatever the sources, mode and saturate setting.
- R7: An operation accepted at a rising edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after the third rising edge, counting the accepting edge, provided `out_ready` stays high. Operations issued on consecutive cycles come out on consecutive cycles.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and both `out_valid` and `result` hold their values.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can take an operation this cycle |
| mode_word | input | 1 | 0: byte elements (unsigned × signed); 1: 16-bit elements (signed × signed) |
| sat_en | input | 1 | 1: clamp the accumulate; 0: wrap |
| wr_mask | input | LANES | Per-lane write enable |
| src_a | input | 32*LANES | First multiplicand vector |
| src_b | input | 32*LANES | Second multiplicand vector |
| acc_in | input | 32*LANES | Accumulator vector |
| out_valid | output | 1 | `result` holds a finished operation |
| out_ready | input | 1 | The consumer takes the result this cycle |
| result | output | 32*LANES | Updated accumulator vector |

## Verification
The hardest cases to reach are at the accumulate stage. There the full-precision sum has to exceed the 32-bit range, so that wrap and clamp give different answers. Random operands almost never get there. The bench therefore drives directed extremes: every 16-bit half set to 0x8000 makes each word-mode lane sum exactly 2^31. Worst-case byte operands combined with an accumulator of 0x80000000 push the result below the signed minimum. A separate scenario holds `out_ready` low while results sit in the pipeline, and then checks that nothing moves.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
   localparam int BYTE_W  = 8;
   localparam int HALF_W  = 2 * BYTE_W;
   localparam int ACC_W   = 2 * HALF_W;
   localparam int GROUP   = ACC_W / BYTE_W;     // byte products per lane
   localparam int PAIR    = ACC_W / HALF_W;     // half products per lane
   localparam int BPROD_W = 2 * BYTE_W + 1;     // unsigned x signed byte product
   localparam int PROD_W  = 2 * HALF_W;         // product slot width
   localparam int SUM_W   = PROD_W + 2;         // full-precision group sum
   localparam int EXT_W   = SUM_W + 1;          // accumulate width

   typedef logic [GROUP-1:0][PROD_W-1:0] prod_vec_t;
endpackage

// File: rtl/dpa_mul.sv
module dpa_mul
   import dpa_pkg::*;
(
   input  logic [ACC_W-1:0] a,
   input  logic [ACC_W-1:0] b,
   input  logic             word_mode,
   output prod_vec_t        prod
);
   generate
      for (genvar i = 0; i < GROUP; i++) begin : g_slot
         logic signed [BPROD_W-1:0] ua, sb, pb;
         logic        [PROD_W-1:0]  byte_ext;
         assign ua = {{(BPROD_W-BYTE_W){1'b0}}, a[i*BYTE_W +: BYTE_W]};
         assign sb = {{(BPROD_W-BYTE_W){b[i*BYTE_W+BYTE_W-1]}}, b[i*BYTE_W +: BYTE_W]};
         assign pb = ua * sb;
         assign byte_ext = {{(PROD_W-BPROD_W){pb[BPROD_W-1]}}, pb};
         if (i < PAIR) begin : g_word
            logic signed [PROD_W-1:0] wa, wb, pw;
            assign wa = {{(PROD_W-HALF_W){a[i*HALF_W+HALF_W-1]}}, a[i*HALF_W +: HALF_W]};
            assign wb = {{(PROD_W-HALF_W){b[i*HALF_W+HALF_W-1]}}, b[i*HALF_W +: HALF_W]};
            assign pw = wa * wb;
            assign prod[i] = word_mode ? pw : byte_ext;
         end else begin : g_byte_only
            assign prod[i] = word_mode ? '0 : byte_ext;
         end
      end
   endgenerate
endmodule

// File: rtl/dpa_sat_add.sv
module dpa_sat_add
   import dpa_pkg::*;
(
   input  logic [ACC_W-1:0] acc,
   input  logic [SUM_W-1:0] sum,
   input  logic             sat,
   output logic [ACC_W-1:0] y
);
   localparam int TOP_W = EXT_W - ACC_W + 1;
   logic [EXT_W-1:0] total;
   logic [TOP_W-1:0] top;

   assign total = {{(EXT_W-ACC_W){acc[ACC_W-1]}}, acc} + {sum[SUM_W-1], sum};
   assign top   = total[EXT_W-1:ACC_W-1];

   always_comb begin
      y = total[ACC_W-1:0];
      if (sat && (top != '0) && (top != '1)) begin
         y = total[EXT_W-1] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
      end
   end
endmodule

// File: rtl/dpa_lane.sv
module dpa_lane
   import dpa_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             v2,
   input  logic [ACC_W-1:0] a,
   input  logic [ACC_W-1:0] b,
   input  logic [ACC_W-1:0] acc,
   input  logic             word_mode,
   input  logic             sat,
   input  logic             wen,
   output logic [ACC_W-1:0] res
);
   prod_vec_t               prod_c, prod1;
   logic [ACC_W-1:0]        acc1, acc2, sum_y;
   logic                    wen1, wen2, mode1, mode2, sat1, sat2;
   logic signed [SUM_W-1:0] sum_c, sum2;

   dpa_mul i_mul (.a(a), .b(b), .word_mode(word_mode), .prod(prod_c));

   always_comb begin
      sum_c = '0;
      for (int i = 0; i < GROUP; i++) begin
         sum_c = sum_c + {{(SUM_W-PROD_W){prod1[i][PROD_W-1]}}, prod1[i]};
      end
   end

   dpa_sat_add i_add (.acc(acc2), .sum(sum2), .sat(sat2), .y(sum_y));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod1 <= '0; acc1 <= '0; wen1 <= 1'b0; mode1 <= 1'b0; sat1 <= 1'b0;
         sum2  <= '0; acc2 <= '0; wen2 <= 1'b0; mode2 <= 1'b0; sat2 <= 1'b0;
         res   <= '0;
      end else if (adv) begin
         prod1 <= prod_c; acc1 <= acc; wen1 <= wen; mode1 <= word_mode; sat1 <= sat;
         sum2  <= sum_c;  acc2 <= acc1; wen2 <= wen1; mode2 <= mode1; sat2 <= sat1;
         res   <= wen2 ? sum_y : acc2;
      end
   end

   // R3: byte-mode group sum stays inside the exact product range
   assert_group_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (v2 && !mode2) |-> (sum2 >= -34'sd130560 && sum2 <= 34'sd129540));

   // R6: a masked lane leaves with its accumulator unchanged
   assert_mask_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && v2 && !wen2) |=> (res == $past(acc2)));

   // R5: clamped sum of two non-negative terms is never negative
   assert_sat_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && v2 && wen2 && sat2 && !acc2[ACC_W-1] && !sum2[SUM_W-1]) |=> !res[ACC_W-1]);
endmodule

// File: rtl/byte_dot_mac.sv
module byte_dot_mac
   import dpa_pkg::*;
#(
   parameter int LANES = 16,
   localparam int VEC_W = LANES * ACC_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             mode_word,
   input  logic             sat_en,
   input  logic [LANES-1:0] wr_mask,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic [VEC_W-1:0] acc_in,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [VEC_W-1:0] result
);
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("byte_dot_mac: LANES must be at least 1");
      end
      if (GROUP * BYTE_W != ACC_W || PAIR * HALF_W != ACC_W) begin : g_bad_widths
         $error("byte_dot_mac: lane width must be whole bytes and halves");
      end
   endgenerate

   logic adv, v1, v2, v3;

   assign adv       = !(v3 && !out_ready);
   assign in_ready  = adv;
   assign out_valid = v3;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      end else if (adv) begin
         v1 <= in_valid; v2 <= v1; v3 <= v2;
      end
   end

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         dpa_lane i_lane (
            .clk(clk), .rst_n(rst_n), .adv(adv), .v2(v2),
            .a(src_a[k*ACC_W +: ACC_W]), .b(src_b[k*ACC_W +: ACC_W]),
            .acc(acc_in[k*ACC_W +: ACC_W]), .word_mode(mode_word),
            .sat(sat_en), .wen(wr_mask[k]), .res(result[k*ACC_W +: ACC_W]));
      end
   endgenerate

   // R8: a stalled result is held
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(result)));

   // R8: a result only disappears after it was taken
   assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> $past(out_ready));

   // R7: a finished result implies an operation three stages back
   assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(v2));
endmodule

// File: tb/test_byte_dot_mac.sv
module test_byte_dot_mac;
   localparam int LANES = 16;
   localparam int VEC_W = LANES * 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0, in_ready, mode_word = 1'b0, sat_en = 1'b0;
   logic [LANES-1:0] wr_mask = '1;
   logic [VEC_W-1:0] src_a = '0, src_b = '0, acc_in = '0, result;
   logic             out_valid, out_ready = 1'b1;
   int               n_chk = 0, n_fail = 0, cyc = 0;

   byte_dot_mac #(.LANES(LANES)) i_byte_dot_mac (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .mode_word(mode_word), .sat_en(sat_en), .wr_mask(wr_mask),
      .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
      .out_valid(out_valid), .out_ready(out_ready), .result(result));

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL R7 watchdog: actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
         $finish;
      end
   end

   function automatic logic [VEC_W-1:0] model(input logic [VEC_W-1:0] a, b, acc,
         input logic wm, sat, input logic [LANES-1:0] msk);
      logic [VEC_W-1:0] r;
      for (int k = 0; k < LANES; k++) begin
         longint s = 0;
         longint t;
         if (!wm) begin
            for (int i = 0; i < 4; i++)
               s += longint'(a[(4*k+i)*8 +: 8]) * longint'($signed(b[(4*k+i)*8 +: 8]));
         end else begin
            for (int i = 0; i < 2; i++)
               s += longint'($signed(a[(2*k+i)*16 +: 16])) * longint'($signed(b[(2*k+i)*16 +: 16]));
         end
         t = longint'($signed(acc[32*k +: 32])) + s;
         if (sat && t > 64'sd2147483647)  t = 64'sd2147483647;
         if (sat && t < -64'sd2147483648) t = -64'sd2147483648;
         r[32*k +: 32] = msk[k] ? t[31:0] : acc[32*k +: 32];
      end
      return r;
   endfunction

   function automatic logic [VEC_W-1:0] rnd();
      logic [VEC_W-1:0] v;
      for (int k = 0; k < LANES; k++) v[32*k +: 32] = $urandom();
      return v;
   endfunction

   function automatic logic [VEC_W-1:0] fill8(input logic [7:0] x);
      return {(VEC_W/8){x}};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [VEC_W-1:0] act, exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one operation through the pipeline with the consumer always ready; starts and ends at a negedge
   task automatic run_op(input string req, input logic [VEC_W-1:0] a, b, acc,
         input logic wm, sat, input logic [LANES-1:0] msk);
      logic [VEC_W-1:0] exp;
      exp = model(a, b, acc, wm, sat, msk);
      src_a = a; src_b = b; acc_in = acc; mode_word = wm; sat_en = sat; wr_mask = msk;
      in_valid = 1'b1; out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      src_a = rnd(); src_b = rnd(); acc_in = rnd();
      @(posedge clk); @(negedge clk);
      chk(out_valid == 1'b0, "R7 early", {511'b0, out_valid}, '0);
      @(posedge clk); @(negedge clk);
      chk(out_valid == 1'b1, "R7 valid", {511'b0, out_valid}, 1);
      chk(result == exp, req, result, exp);
   endtask

   task automatic t_reset();
      chk(out_valid == 1'b0 && in_ready == 1'b1, "R9 reset",
          {510'b0, out_valid, in_ready}, 1);
   endtask

   task automatic t_byte();
      run_op("R1 random", rnd(), rnd(), rnd(), 1'b0, 1'b0, '1);
      run_op("R1 ff x 7f", fill8(8'hFF), fill8(8'h7F), rnd(), 1'b0, 1'b0, '1);
      run_op("R1 80 x 80", fill8(8'h80), fill8(8'h80), '0, 1'b0, 1'b0, '1);
      run_op("R1 random sat", rnd(), rnd(), rnd(), 1'b0, 1'b1, '1);
   endtask

   task automatic t_word();
      run_op("R2 random", rnd(), rnd(), rnd(), 1'b1, 1'b0, '1);
      run_op("R2 7fff x 8000", {(VEC_W/16){16'h7FFF}}, {(VEC_W/16){16'h8000}}, rnd(), 1'b1, 1'b0, '1);
   endtask

   task automatic t_precision();
      run_op("R3 worst byte sum", fill8(8'hFF), fill8(8'h80), '0, 1'b0, 1'b0, '1);
      chk(result[31:0] == 32'hFFFE0200, "R3 lane0", {480'b0, result[31:0]}, {480'b0, 32'hFFFE0200});
   endtask

   task automatic t_overflow();
      logic [VEC_W-1:0] h8000, amin;
      h8000 = {(VEC_W/16){16'h8000}};
      amin  = {LANES{32'h80000000}};
      run_op("R4 word wrap", h8000, h8000, '0, 1'b1, 1'b0, '1);
      chk(result[31:0] == 32'h80000000, "R4 lane0", {480'b0, result[31:0]}, {480'b0, 32'h80000000});
      run_op("R5 word clamp", h8000, h8000, '0, 1'b1, 1'b1, '1);
      chk(result[31:0] == 32'h7FFFFFFF, "R5 lane0", {480'b0, result[31:0]}, {480'b0, 32'h7FFFFFFF});
      run_op("R4 byte wrap low", fill8(8'hFF), fill8(8'h80), amin, 1'b0, 1'b0, '1);
      run_op("R5 byte clamp low", fill8(8'hFF), fill8(8'h80), amin, 1'b0, 1'b1, '1);
      chk(result[31:0] == 32'h80000000, "R5 lane0 low", {480'b0, result[31:0]}, {480'b0, 32'h80000000});
   endtask

   task automatic t_mask();
      logic [VEC_W-1:0] acc;
      acc = rnd();
      run_op("R6 mask a5a5", rnd(), rnd(), acc, 1'b0, 1'b0, 16'hA5A5);
      chk(result[63:32] == acc[63:32], "R6 lane1 kept", {480'b0, result[63:32]}, {480'b0, acc[63:32]});
      run_op("R6 mask none sat", {(VEC_W/16){16'h8000}}, {(VEC_W/16){16'h8000}}, acc, 1'b1, 1'b1, '0);
   endtask

   task automatic t_stream();
      logic [VEC_W-1:0] exp [4];
      for (int i = 0; i < 7; i++) begin
         if (i >= 3) chk(out_valid && result == exp[i-3], "R7 back-to-back", result, exp[i-3]);
         if (i < 4) begin
            src_a = rnd(); src_b = rnd(); acc_in = rnd();
            mode_word = i[0]; sat_en = i[1]; wr_mask = 16'hFFFF ^ (16'h1 << i);
            exp[i] = model(src_a, src_b, acc_in, mode_word, sat_en, wr_mask);
            in_valid = 1'b1; out_ready = 1'b1;
         end else begin
            in_valid = 1'b0;
         end
         @(posedge clk); @(negedge clk);
      end
   endtask

   task automatic t_stall();
      logic [VEC_W-1:0] exp;
      src_a = rnd(); src_b = rnd(); acc_in = rnd(); mode_word = 1'b0; sat_en = 1'b0; wr_mask = '1;
      exp = model(src_a, src_b, acc_in, 1'b0, 1'b0, '1);
      in_valid = 1'b1; out_ready = 1'b0;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      repeat (2) begin @(posedge clk); @(negedge clk); end
      chk(out_valid && !in_ready, "R8 stalled", {510'b0, out_valid, in_ready}, 2);
      repeat (4) begin @(posedge clk); @(negedge clk); end
      chk(out_valid && !in_ready && result == exp, "R8 held", result, exp);
      out_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      chk(!out_valid && in_ready, "R8 released", {510'b0, out_valid, in_ready}, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_byte();
      t_word();
      t_precision();
      t_overflow();
      t_mask();
      t_stream();
      t_stall();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule